// File: doc/BRIEF.md
# Framed Register-Access Command Responder

This block is the device-side engine behind a byte-stream register bus. Command bytes arrive one at a time on a valid/ready input stream. The engine looks for a start marker and collects an opcode, an address and, for writes, a data word. It then checks that the closing marker is present. A well-formed command becomes one access on a simple register port, which has a 16-bit address and a 32-bit data word. The engine then sends a framed reply one byte at a time on a valid/ready output stream.

The length and content of each reply depend on the outcome:

| Outcome | Reply length | Status byte |
|---|---|---|
| Read | 9 bytes | 0x7F |
| Write | 5 bytes | 0x7E |
| Reset | 3 bytes | 0x7D |
| Missing closing marker | 4 bytes | 0xFD |
| Unrecognised opcode | 4 bytes | 0xFE |

The 4-byte error replies echo the byte that caused the error. While no command is open, stray bytes are dropped until a start marker appears. The input stays closed from the last byte of a command until the last byte of its reply has left.

Top module: `cmd_frame_responder`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and reg_rd, reg_wr and reg_rst are all 0.
- R2: While idle, any input byte other than 0x55 is consumed and dropped. It produces no output byte and no register strobe.
- R3: The read command is 0x55, 0x10, address high, address low, 0xAA.
  - It causes one reg_rd pulse carrying that address.
  - reg_rdata is taken in the cycle after the pulse.
  - The reply is 0xAA, 0x7F, address high, address low, the four data bytes with the most significant first, then 0x55.
- R4: The write command is 0x55, 0x11, address high, address low, four data bytes with the most significant first, 0xAA.
  - It causes one reg_wr pulse carrying that address and data.
  - The reply is 0xAA, 0x7E, address high, address low, 0x55.
- R5: The reset command is 0x55, 0x01, 0xAA. It causes one reg_rst pulse, and the reply is 0xAA, 0x7D, 0x55.
- R6: Any opcode byte other than 0x10, 0x11 or 0x01 closes the command at once.
  - The reply is 0xAA, 0xFE, the opcode, 0x55.
  - No register strobe is issued.
- R7: If the byte in the closing-marker position is not 0xAA, the reply is 0xAA, 0xFD, that byte, 0x55.
  - This applies to read, write and reset commands alike.
  - No register strobe is issued.
- R8: From the closing byte of a command (or its bad opcode) until the last reply byte is accepted, in_ready is 0. Afterwards in_ready returns to 1.
- R9: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_data does not change on the next cycle.
- R10: At most one of reg_rd, reg_wr and reg_rst is high in any cycle. Each pulse lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command byte is offered |
| in_data | input | 8 | Command byte |
| in_ready | output | 1 | Engine accepts a command byte |
| out_valid | output | 1 | Reply byte is offered |
| out_data | output | 8 | Reply byte |
| out_ready | input | 1 | Consumer accepts the reply byte |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_rst | output | 1 | One-cycle reset strobe |
| reg_addr | output | 16 | Register address |
| reg_wdata | output | 32 | Write data |
| reg_rdata | input | 32 | Read data, valid the cycle after reg_rd |

## Verification
A parser that loses its place in a frame shows up in the reply that follows. The status byte, the echoed byte or the reply length comes out wrong, or a register strobe appears where none should. A slip in the address or data byte order shows up only in the echoed address bytes or in later read-back data. Write data is therefore checked again by reading it back through a later read command. Errors in reply sequencing appear within a few cycles as extra or missing output bytes, or as in_ready reopening before the final reply byte.

// File: rtl/cfr_pkg.sv
package cfr_pkg;

  localparam logic [7:0] FRM_OPEN   = 8'h55;
  localparam logic [7:0] FRM_CLOSE  = 8'hAA;
  localparam logic [7:0] RSP_OPEN   = 8'hAA;
  localparam logic [7:0] RSP_CLOSE  = 8'h55;

  localparam logic [7:0] OPC_RD     = 8'h10;
  localparam logic [7:0] OPC_WR     = 8'h11;
  localparam logic [7:0] OPC_RST    = 8'h01;

  localparam logic [7:0] ST_RD_OK   = 8'h7F;
  localparam logic [7:0] ST_WR_OK   = 8'h7E;
  localparam logic [7:0] ST_RST_OK  = 8'h7D;
  localparam logic [7:0] ST_BAD_END = 8'hFD;
  localparam logic [7:0] ST_UNKNOWN = 8'hFE;

  typedef enum logic [2:0] {
    K_READ,
    K_WRITE,
    K_RESET,
    K_BADEND,
    K_UNKNOWN
  } cmd_kind_e;

  function automatic logic [7:0] status_of(cmd_kind_e k);
    case (k)
      K_READ:   return ST_RD_OK;
      K_WRITE:  return ST_WR_OK;
      K_RESET:  return ST_RST_OK;
      K_BADEND: return ST_BAD_END;
      default:  return ST_UNKNOWN;
    endcase
  endfunction

endpackage

// File: rtl/cfr_rx_parse.sv
module cfr_rx_parse
  import cfr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  input  logic              tx_done,
  output logic              cmd_valid,
  output cmd_kind_e         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic [7:0]        cmd_bad
);
  localparam int ADDR_B = ADDR_W / 8;
  localparam int DATA_B = DATA_W / 8;
  localparam int MAX_B  = (ADDR_B > DATA_B) ? ADDR_B : DATA_B;
  localparam int CNT_W  = $clog2(MAX_B + 1);

  typedef enum logic [2:0] {P_IDLE, P_OPC, P_ADDR, P_DATA, P_END, P_WAIT} pstate_e;

  pstate_e           state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  cmd_kind_e         kind_q, kind_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [7:0]        bad_q, bad_d;
  logic              valid_q, valid_d;
  logic              take;

  assign in_ready = (state_q != P_WAIT);
  assign take     = in_valid & in_ready;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    kind_d  = kind_q;
    addr_d  = addr_q;
    data_d  = data_q;
    bad_d   = bad_q;
    valid_d = 1'b0;
    case (state_q)
      P_IDLE: if (take && in_data == FRM_OPEN) state_d = P_OPC;
      P_OPC: if (take) begin
        cnt_d = '0;
        case (in_data)
          OPC_RD:  begin kind_d = K_READ;  state_d = P_ADDR; end
          OPC_WR:  begin kind_d = K_WRITE; state_d = P_ADDR; end
          OPC_RST: begin kind_d = K_RESET; state_d = P_END;  end
          default: begin
            kind_d  = K_UNKNOWN;
            bad_d   = in_data;
            valid_d = 1'b1;
            state_d = P_WAIT;
          end
        endcase
      end
      P_ADDR: if (take) begin
        addr_d = (addr_q << 8) | ADDR_W'(in_data);
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(ADDR_B - 1)) begin
          cnt_d   = '0;
          state_d = (kind_q == K_WRITE) ? P_DATA : P_END;
        end
      end
      P_DATA: if (take) begin
        data_d = (data_q << 8) | DATA_W'(in_data);
        cnt_d  = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(DATA_B - 1)) begin
          cnt_d   = '0;
          state_d = P_END;
        end
      end
      P_END: if (take) begin
        if (in_data != FRM_CLOSE) begin
          kind_d = K_BADEND;
          bad_d  = in_data;
        end
        valid_d = 1'b1;
        state_d = P_WAIT;
      end
      P_WAIT: if (tx_done) state_d = P_IDLE;
      default: state_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= P_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_READ;
      addr_q  <= '0;
      data_q  <= '0;
      bad_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      bad_q   <= bad_d;
      valid_q <= valid_d;
    end
  end

  assign cmd_valid = valid_q;
  assign cmd_kind  = kind_q;
  assign cmd_addr  = addr_q;
  assign cmd_data  = data_q;
  assign cmd_bad   = bad_q;

endmodule

// File: rtl/cfr_reg_issue.sv
module cfr_reg_issue
  import cfr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  cmd_kind_e         cmd_kind,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic [7:0]        cmd_bad,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic              reg_rst,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              rsp_valid,
  output cmd_kind_e         rsp_kind,
  output logic [DATA_W-1:0] rsp_data,
  output logic [7:0]        rsp_bad
);
  logic              rd_q, wr_q, rst_q, rd_wait_q, rsp_valid_q;
  logic              rd_d, wr_d, rst_d, rd_wait_d, rsp_valid_d;
  logic              hold_en, cap_en;
  cmd_kind_e         kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [7:0]        bad_q;

  always_comb begin
    hold_en     = cmd_valid;
    cap_en      = rd_wait_q;
    rd_d        = cmd_valid & (cmd_kind == K_READ);
    wr_d        = cmd_valid & (cmd_kind == K_WRITE);
    rst_d       = cmd_valid & (cmd_kind == K_RESET);
    rd_wait_d   = rd_q;
    rsp_valid_d = (cmd_valid & (cmd_kind != K_READ)) | rd_wait_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q        <= 1'b0;
      wr_q        <= 1'b0;
      rst_q       <= 1'b0;
      rd_wait_q   <= 1'b0;
      rsp_valid_q <= 1'b0;
    end else begin
      rd_q        <= rd_d;
      wr_q        <= wr_d;
      rst_q       <= rst_d;
      rd_wait_q   <= rd_wait_d;
      rsp_valid_q <= rsp_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q  <= K_READ;
      addr_q  <= '0;
      wdata_q <= '0;
      bad_q   <= '0;
    end else if (hold_en) begin
      kind_q  <= cmd_kind;
      addr_q  <= cmd_addr;
      wdata_q <= cmd_data;
      bad_q   <= cmd_bad;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cap_en) rdata_q <= reg_rdata;
  end

  assign reg_rd    = rd_q;
  assign reg_wr    = wr_q;
  assign reg_rst   = rst_q;
  assign reg_addr  = addr_q;
  assign reg_wdata = wdata_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_kind  = kind_q;
  assign rsp_data  = rdata_q;
  assign rsp_bad   = bad_q;

endmodule

// File: rtl/cfr_tx_ser.sv
module cfr_tx_ser
  import cfr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rsp_valid,
  input  cmd_kind_e         rsp_kind,
  input  logic [ADDR_W-1:0] rsp_addr,
  input  logic [DATA_W-1:0] rsp_data,
  input  logic [7:0]        rsp_bad,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              tx_done
);
  localparam int ADDR_B  = ADDR_W / 8;
  localparam int DATA_B  = DATA_W / 8;
  localparam int LEN_MAX = 3 + ADDR_B + DATA_B;
  localparam int IDX_W   = $clog2(LEN_MAX + 1);

  logic [7:0] addr_byte [ADDR_B];
  logic [7:0] data_byte [DATA_B];

  for (genvar g = 0; g < ADDR_B; g++) begin : g_addr_bytes
    assign addr_byte[g] = rsp_addr[ADDR_W-1-8*g -: 8];
  end
  for (genvar g = 0; g < DATA_B; g++) begin : g_data_bytes
    assign data_byte[g] = rsp_data[DATA_W-1-8*g -: 8];
  end

  function automatic logic [IDX_W-1:0] len_of(cmd_kind_e k);
    case (k)
      K_READ:  return IDX_W'(3 + ADDR_B + DATA_B);
      K_WRITE: return IDX_W'(3 + ADDR_B);
      K_RESET: return IDX_W'(3);
      default: return IDX_W'(4);
    endcase
  endfunction

  logic             active_q, active_d;
  logic [IDX_W-1:0] idx_q, idx_d, len_q, len_d;
  logic             last;
  logic             step;

  assign last    = (idx_q == len_q - 1'b1);
  assign step    = active_q & out_ready;
  assign tx_done = step & last;

  always_comb begin
    active_d = active_q;
    idx_d    = idx_q;
    len_d    = len_q;
    if (rsp_valid) begin
      active_d = 1'b1;
      idx_d    = '0;
      len_d    = len_of(rsp_kind);
    end else if (step) begin
      if (last) active_d = 1'b0;
      else      idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      len_q    <= '0;
    end else begin
      active_q <= active_d;
      idx_q    <= idx_d;
      len_q    <= len_d;
    end
  end

  always_comb begin
    out_data = RSP_CLOSE;
    if (idx_q == '0) begin
      out_data = RSP_OPEN;
    end else if (last) begin
      out_data = RSP_CLOSE;
    end else if (idx_q == IDX_W'(1)) begin
      out_data = status_of(rsp_kind);
    end else if (rsp_kind == K_BADEND || rsp_kind == K_UNKNOWN) begin
      out_data = rsp_bad;
    end else begin
      for (int i = 0; i < ADDR_B; i++)
        if (idx_q == IDX_W'(2 + i)) out_data = addr_byte[i];
      for (int i = 0; i < DATA_B; i++)
        if (idx_q == IDX_W'(2 + ADDR_B + i)) out_data = data_byte[i];
    end
  end

  assign out_valid = active_q;

endmodule

// File: rtl/cmd_frame_responder.sv
module cmd_frame_responder
  import cfr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [7:0]        out_data,
  input  logic              out_ready,
  output logic              reg_rd,
  output logic              reg_wr,
  output logic              reg_rst,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic              cmd_valid, rsp_valid, tx_done;
  cmd_kind_e         cmd_kind, rsp_kind;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DATA_W-1:0] cmd_data, rsp_data;
  logic [7:0]        cmd_bad, rsp_bad;

  cfr_rx_parse #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_parse (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .tx_done   (tx_done),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_bad   (cmd_bad)
  );

  cfr_reg_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cmd_addr  (cmd_addr),
    .cmd_data  (cmd_data),
    .cmd_bad   (cmd_bad),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_rst   (reg_rst),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_data  (rsp_data),
    .rsp_bad   (rsp_bad)
  );

  cfr_tx_ser #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .rsp_kind  (rsp_kind),
    .rsp_addr  (reg_addr),
    .rsp_data  (rsp_data),
    .rsp_bad   (rsp_bad),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .tx_done   (tx_done)
  );

endmodule

// File: rtl/cfr_checker.sv
module cfr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       in_ready,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_ready,
  input logic       reg_rd,
  input logic       reg_wr,
  input logic       reg_rst
);
  // R8: the input stays closed while a reply byte is on offer
  a_r8_closed_while_replying: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  // R9: a stalled reply byte is held
  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10: strobes never overlap
  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_rd, reg_wr, reg_rst}));

  // R10: each strobe is a single-cycle pulse
  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);
  a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);
  a_r10_rst_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rst |=> !reg_rst);

  // R3: the read reply waits for the data fetch
  a_r3_no_reply_during_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !out_valid);

  // R5: no reply byte is on offer in the strobe cycle of a reset
  a_r5_strobe_before_reply: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rst |-> !out_valid);
endmodule

bind cmd_frame_responder cfr_checker u_cfr_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_ready (out_ready),
  .reg_rd    (reg_rd),
  .reg_wr    (reg_wr),
  .reg_rst   (reg_rst)
);

// File: tb/cmd_frame_responder_bench.sv
module cmd_frame_responder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [7:0]  out_data;
  logic        out_ready = 1'b1;
  logic        reg_rd, reg_wr, reg_rst;
  logic [15:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] rdata_q = 32'h0;

  always #5 clk = ~clk;

  cmd_frame_responder u_cmd_frame_responder (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_rst(reg_rst),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_q)
  );

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, n_rst = 0;
  int bp_pct = 0;
  logic [15:0] last_rd_addr = 16'h0, last_wr_addr = 16'h0;
  logic [31:0] last_wr_data = 32'h0;
  logic [31:0] model_mem [16];
  logic [31:0] shadow [16];
  logic [7:0]  rxq [$];
  logic        hold_prev = 1'b0;
  logic [7:0]  prev_data = 8'h00;
  bit          done = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Register-port model, reply collector and back-pressure source
  always @(negedge clk) begin
    if (hold_prev)  // R9 at the ports
      chk(out_valid && out_data == prev_data, "R9 stalled byte held",
          {out_valid, out_data}, {1'b1, prev_data});
    out_ready = ($urandom_range(99) >= bp_pct);
    hold_prev = out_valid && !out_ready;
    prev_data = out_data;
    if (out_valid && out_ready) rxq.push_back(out_data);
    if (reg_wr) begin
      model_mem[reg_addr[3:0]] = reg_wdata;
      last_wr_addr = reg_addr;
      last_wr_data = reg_wdata;
      n_wr++;
    end
    if (reg_rd) begin
      rdata_q = model_mem[reg_addr[3:0]];
      last_rd_addr = reg_addr;
      n_rd++;
    end
    if (reg_rst) n_rst++;
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic run_cmd(input logic [7:0] cmd[$], input logic [7:0] exp[$],
                         input int e_rd, input int e_wr, input int e_rst, input string tag);
    int rd0 = n_rd, wr0 = n_wr, rst0 = n_rst, t = 0;
    bit same;
    rxq.delete();
    foreach (cmd[i]) send_byte(cmd[i]);
    @(negedge clk);
    if (exp.size() > 0)
      chk(!in_ready, {tag, " R8 input closed after command"}, in_ready, 0);
    while (rxq.size() < exp.size() && t < 3000) begin
      @(negedge clk);
      t++;
    end
    repeat (6) @(negedge clk);
    same = (rxq.size() == exp.size());
    if (same) foreach (exp[i]) if (rxq[i] != exp[i]) same = 0;
    chk(same, {tag, " reply bytes"},
        (rxq.size() > 0) ? {rxq[0], rxq[rxq.size()-1], 8'(rxq.size())} : 0,
        (exp.size() > 0) ? {exp[0], exp[exp.size()-1], 8'(exp.size())} : 0);
    chk(n_rd - rd0 == e_rd && n_wr - wr0 == e_wr && n_rst - rst0 == e_rst,
        {tag, " R10 strobe counts"}, {n_rd - rd0, n_wr - wr0, n_rst - rst0},
        {e_rd, e_wr, e_rst});
    chk(in_ready, {tag, " R8 input reopens"}, in_ready, 1);
  endtask

  task automatic do_read(input logic [15:0] a);
    logic [7:0] c[$], e[$];
    logic [31:0] d = shadow[a[3:0]];
    c = '{8'h55, 8'h10, a[15:8], a[7:0], 8'hAA};
    e = '{8'hAA, 8'h7F, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], 8'h55};
    run_cmd(c, e, 1, 0, 0, "R3 read");
    chk(last_rd_addr == a, "R3 read address", last_rd_addr, a);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    logic [7:0] c[$], e[$];
    c = '{8'h55, 8'h11, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], 8'hAA};
    e = '{8'hAA, 8'h7E, a[15:8], a[7:0], 8'h55};
    shadow[a[3:0]] = d;
    run_cmd(c, e, 0, 1, 0, "R4 write");
    chk(last_wr_addr == a && last_wr_data == d, "R4 write strobe fields",
        {last_wr_addr, last_wr_data}, {a, d});
  endtask

  task automatic do_reset();
    logic [7:0] c[$], e[$];
    c = '{8'h55, 8'h01, 8'hAA};
    e = '{8'hAA, 8'h7D, 8'h55};
    run_cmd(c, e, 0, 0, 1, "R5 reset");
  endtask

  task automatic do_badop(input logic [7:0] op);
    logic [7:0] c[$], e[$];
    c = '{8'h55, op};
    e = '{8'hAA, 8'hFE, op, 8'h55};
    run_cmd(c, e, 0, 0, 0, "R6 unknown opcode");
  endtask

  task automatic do_badend(input int which, input logic [15:0] a, input logic [31:0] d,
                           input logic [7:0] b);
    logic [7:0] c[$], e[$];
    if (which == 0)      c = '{8'h55, 8'h10, a[15:8], a[7:0], b};
    else if (which == 1) c = '{8'h55, 8'h11, a[15:8], a[7:0], d[31:24], d[23:16], d[15:8], d[7:0], b};
    else                 c = '{8'h55, 8'h01, b};
    e = '{8'hAA, 8'hFD, b, 8'h55};
    run_cmd(c, e, 0, 0, 0, "R7 bad closing byte");
  endtask

  task automatic do_garbage(input int n);
    logic [7:0] c[$], e[$];
    for (int i = 0; i < n; i++) begin
      logic [7:0] g = 8'($urandom_range(255));
      if (g == 8'h55) g = 8'h56;
      c.push_back(g);
    end
    e.delete();
    run_cmd(c, e, 0, 0, 0, "R2 idle bytes dropped");
  endtask

  function automatic logic [7:0] rand_not(input logic [7:0] x);
    logic [7:0] r = 8'($urandom_range(255));
    if (r == x) r = ~x;
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 16; i++) begin
      model_mem[i] = 32'hC0DE0000 + 32'(i * 32'h00001111);
      shadow[i]    = model_mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !reg_rd && !reg_wr && !reg_rst, "R1 reset state",
        {in_ready, out_valid, reg_rd, reg_wr, reg_rst}, 5'b10000);

    // Directed corner cases
    do_garbage(5);
    do_read(16'h1203);
    do_write(16'hBEE5, 32'h55AA55AA);   // data bytes equal to the frame markers
    do_read(16'h0005);
    do_reset();
    do_badop(8'h55);
    do_badop(8'h12);
    do_badend(0, 16'h0001, 32'h0, 8'h55);
    do_badend(1, 16'h0002, 32'h01020304, 8'h00);
    do_badend(2, 16'h0000, 32'h0, 8'hAB);
    do_read(16'h0002);                   // the failed write must not have landed
    bp_pct = 90;
    do_write(16'h7F0A, 32'hDEADBEEF);
    do_read(16'hFF0A);

    // Constrained random mix
    bp_pct = 30;
    for (int k = 0; k < 60; k++) begin
      int sel = $urandom_range(9);
      logic [15:0] a = 16'($urandom_range(65535));
      logic [31:0] d = $urandom;
      case (sel)
        0, 1, 2: do_write(a, d);
        3, 4, 5: do_read(a);
        6:       do_reset();
        7: begin
          logic [7:0] op = 8'($urandom_range(255));
          if (op == 8'h10 || op == 8'h11 || op == 8'h01) op = 8'h20;
          do_badop(op);
        end
        8:       do_badend($urandom_range(2), a, d, rand_not(8'hAA));
        default: do_garbage(1 + $urandom_range(4));
      endcase
    end
    finish_run();
  end

endmodule